// File: doc/BRIEF.md
# I2C Register-Access Target

This block is a two-wire serial target that lets a bus controller read and write a bank of 8-bit registers. It watches the synchronized clock and data lines and finds START and STOP conditions. It compares the first byte of each transfer against a fixed 7-bit device address and takes bytes in or sends them out. Acknowledge bits go out through a single pull-low output on the open-drain data line.

One sub-address pointer is kept across transfers. A write transfer loads the pointer from the byte that follows the device address, and every later byte of that transfer is stored at the pointer. A read transfer sends the register at the pointer, with no sub-address phase. Either kind of burst advances the pointer by one per byte. Random reads are built from a write transfer that sets the pointer, followed by a repeated START and a read transfer.

The register bank sits outside the block. It sees an address, a write-data byte and a one-cycle write strobe, and it returns read data combinationally for the address shown.

Top module: `i2c_reg_target`

## Requirements
- R1: START (data falls while clock high) aborts any transfer and begins address reception. STOP (data rises while clock high) ends the transfer and releases the data line. No register is written by a byte cut short by a START.
- R2: After reset, and whenever the received address byte's upper seven bits differ from DEV_ADDR, the data line is never pulled. This includes the ninth clock and all later bytes until the next START or STOP.
- R3: On a matching address byte with bit 0 equal to 0 (write), the block pulls data low for the ninth clock. The next byte is loaded into the pointer and is also acknowledged.
- R4: Each data byte of a write transfer produces exactly one write strobe, with the pointer as address and the byte as data. The byte is acknowledged, and the pointer then advances by one.
- R5: A write transfer keeps storing and acknowledging data bytes at consecutive addresses until STOP.
- R6: A matching address byte with bit 0 equal to 1 (read) is acknowledged. The block then sends the register at the current pointer, most significant bit first, with no sub-address phase.
- R7: A write transfer carrying only a sub-address, then a repeated START and a read address, returns the register at that sub-address.
- R8: In a read, a controller acknowledge (data low on the ninth clock) makes the block send the register at the next address. A not-acknowledge ends the burst, and the data line stays released.
- R9: The pointer resets to 0. It wraps from 2^AW-1 to 0 on both reads and writes, and it keeps its value from one transfer to the next.
- R10: The block changes its data pull only while the synchronized clock is low, and it never pulls during the controller's acknowledge bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, well above the bus bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| reg_addr_o | output | AW | Register address (current pointer) |
| reg_wdata_o | output | 8 | Register write data |
| reg_we_o | output | 1 | One-cycle register write strobe |
| reg_rdata_i | input | 8 | Register read data for reg_addr_o |

## Verification
Byte writes and random-address reads are first run as pairs from a table. The table holds boundary addresses and all-zero, all-one and alternating data. A stuck or swapped data bit shows up as a read-back mismatch, and a wrong address shows up in the bank contents. Bursts are then run across the top of the address space, in both directions. These separate wrap and increment faults from byte-store faults. Current-address reads after each burst show whether the pointer survives STOP. A wrong device address and a START inside a data byte check that traffic is ignored and that no write escapes.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_SUB,
    ST_SUB_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RDATA_ACK
  } tgt_state_e;

endpackage

// File: rtl/i2c_tgt_sync_bit.sv
module i2c_tgt_sync_bit #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= {STAGES{RESET_VAL}};
    end else begin
      pipe_q <= {pipe_q[STAGES-2:0], d_i};
    end
  end

  assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/i2c_tgt_busmon.sv
module i2c_tgt_busmon #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s_o,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  localparam int unsigned NLINES = 2;

  logic [NLINES-1:0] raw;
  logic [NLINES-1:0] synced;
  logic              scl_q;
  logic              sda_q;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    i2c_tgt_sync_bit #(
      .STAGES   (SYNC_STAGES),
      .RESET_VAL(1'b1)
    ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  (raw[g]),
      .q_o  (synced[g])
    );
  end

  assign scl_s_o = synced[0];
  assign sda_s_o = synced[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_o;
      sda_q <= sda_s_o;
    end
  end

  assign scl_rise_o = scl_s_o & ~scl_q;
  assign scl_fall_o = ~scl_s_o & scl_q;
  assign start_o    = scl_s_o & scl_q & sda_q & ~sda_s_o;
  assign stop_o     = scl_s_o & scl_q & ~sda_q & sda_s_o;

endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR = 7'h2A,
  parameter int unsigned AW       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [BYTE_W-1:0] reg_rdata_i,
  output logic              sda_pull_o,
  output logic [AW-1:0]     reg_addr_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  output logic              reg_we_o
);

  localparam int unsigned CNT_W    = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  tgt_state_e        state_q, state_d;
  logic [CNT_W-1:0]  bitcnt_q, bitcnt_d;
  logic              done_q, done_d;
  logic [BYTE_W-1:0] rx_q, rx_d;
  logic [BYTE_W-1:0] tx_q, tx_d;
  logic              rw_q, rw_d;
  logic              mack_q, mack_d;
  logic [AW-1:0]     ptr_q, ptr_d;
  logic              we_q, we_d;
  logic [BYTE_W-1:0] wdata_q, wdata_d;
  logic              receiving;

  assign receiving = (state_q == ST_ADDR) || (state_q == ST_SUB) ||
                     (state_q == ST_WDATA);

  always_comb begin
    state_d  = state_q;
    bitcnt_d = bitcnt_q;
    done_d   = done_q;
    rx_d     = rx_q;
    tx_d     = tx_q;
    rw_d     = rw_q;
    mack_d   = mack_q;
    ptr_d    = ptr_q;
    we_d     = 1'b0;
    wdata_d  = wdata_q;

    // pointer advances the cycle after a write strobe so the strobe sees the old address
    if (we_q) begin
      ptr_d = ptr_q + 1'b1;
    end

    if (start_i) begin
      state_d  = ST_ADDR;
      bitcnt_d = '0;
      done_d   = 1'b0;
    end else if (stop_i) begin
      state_d  = ST_IDLE;
      bitcnt_d = '0;
      done_d   = 1'b0;
    end else if (receiving) begin
      if (scl_rise_i) begin
        rx_d = {rx_q[BYTE_W-2:0], sda_s_i};
        if (bitcnt_q == LAST_BIT) begin
          done_d = 1'b1;
        end else begin
          bitcnt_d = bitcnt_q + 1'b1;
        end
      end else if (scl_fall_i && done_q) begin
        done_d   = 1'b0;
        bitcnt_d = '0;
        unique case (state_q)
          ST_ADDR: begin
            if (rx_q[BYTE_W-1:1] == DEV_ADDR) begin
              state_d = ST_ADDR_ACK;
              rw_d    = rx_q[0];
            end else begin
              state_d = ST_IDLE;
            end
          end
          ST_SUB: begin
            ptr_d   = rx_q[AW-1:0];
            state_d = ST_SUB_ACK;
          end
          default: begin
            we_d    = 1'b1;
            wdata_d = rx_q;
            state_d = ST_WDATA_ACK;
          end
        endcase
      end
    end else begin
      unique case (state_q)
        ST_ADDR_ACK: begin
          if (scl_fall_i) begin
            if (rw_q) begin
              state_d  = ST_RDATA;
              tx_d     = reg_rdata_i;
              bitcnt_d = '0;
              done_d   = 1'b0;
            end else begin
              state_d = ST_SUB;
            end
          end
        end
        ST_SUB_ACK, ST_WDATA_ACK: begin
          if (scl_fall_i) begin
            state_d = ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_rise_i) begin
            if (bitcnt_q == LAST_BIT) begin
              done_d = 1'b1;
            end else begin
              bitcnt_d = bitcnt_q + 1'b1;
            end
          end else if (scl_fall_i) begin
            if (done_q) begin
              state_d  = ST_RDATA_ACK;
              done_d   = 1'b0;
              bitcnt_d = '0;
              ptr_d    = ptr_q + 1'b1;
            end else begin
              tx_d = {tx_q[BYTE_W-2:0], 1'b0};
            end
          end
        end
        ST_RDATA_ACK: begin
          if (scl_rise_i) begin
            mack_d = ~sda_s_i;
          end else if (scl_fall_i) begin
            if (mack_q) begin
              state_d = ST_RDATA;
              tx_d    = reg_rdata_i;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        default: begin
          state_d = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      bitcnt_q <= '0;
      done_q   <= 1'b0;
      rx_q     <= '0;
      tx_q     <= '0;
      rw_q     <= 1'b0;
      mack_q   <= 1'b0;
      ptr_q    <= '0;
      we_q     <= 1'b0;
      wdata_q  <= '0;
    end else begin
      state_q  <= state_d;
      bitcnt_q <= bitcnt_d;
      done_q   <= done_d;
      rx_q     <= rx_d;
      tx_q     <= tx_d;
      rw_q     <= rw_d;
      mack_q   <= mack_d;
      ptr_q    <= ptr_d;
      we_q     <= we_d;
      wdata_q  <= wdata_d;
    end
  end

  assign sda_pull_o  = (state_q == ST_ADDR_ACK) || (state_q == ST_SUB_ACK) ||
                       (state_q == ST_WDATA_ACK) ||
                       ((state_q == ST_RDATA) && !tx_q[BYTE_W-1]);
  assign reg_addr_o  = ptr_q;
  assign reg_wdata_o = wdata_q;
  assign reg_we_o    = we_q;

endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h2A,
  parameter int unsigned AW          = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  output logic [AW-1:0]     reg_addr_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  input  logic [BYTE_W-1:0] reg_rdata_i
);

  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  logic       scl_s;
  logic       sda_s;
  logic       scl_rise;
  logic       scl_fall;
  logic       start_det;
  logic       stop_det;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_sync_n = rst_pipe_q[1];

  i2c_tgt_busmon #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_busmon (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s_o   (scl_s),
    .sda_s_o   (sda_s),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_det),
    .stop_o    (stop_det)
  );

  i2c_tgt_ctrl #(
    .DEV_ADDR(DEV_ADDR),
    .AW      (AW)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .sda_s_i    (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .reg_rdata_i(reg_rdata_i),
    .sda_pull_o (sda_pull_o),
    .reg_addr_o (reg_addr_o),
    .reg_wdata_o(reg_wdata_o),
    .reg_we_o   (reg_we_o)
  );

endmodule

// File: rtl/i2c_tgt_chk.sv
module i2c_tgt_chk #(
  parameter int unsigned AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_s,
  input logic          start_det,
  input logic          stop_det,
  input logic          sda_pull,
  input logic          we,
  input logic [AW-1:0] addr
);

  // R1: a STOP always leaves the data line released
  p_stop_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_pull);

  // R4: every write strobe lasts a single cycle
  p_we_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> !we);

  // R9: after a strobe the address moves up by one, modulo 2^AW
  p_ptr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (addr == $past(addr) + 1'b1));

  // R10: the pull output moves only while the synchronized clock is low
  p_sda_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_pull) && !$past(start_det) && !$past(stop_det)) |-> !scl_s);

endmodule

bind i2c_reg_target i2c_tgt_chk #(
  .AW(AW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .scl_s    (scl_s),
  .start_det(start_det),
  .stop_det (stop_det),
  .sda_pull (sda_pull_o),
  .we       (reg_we_o),
  .addr     (reg_addr_o)
);

// File: tb/sim_i2c_reg_target.sv
module sim_i2c_reg_target;

  localparam logic [6:0] DEV   = 7'h2A;
  localparam int         AW    = 8;
  localparam int         NREG  = 1 << AW;
  localparam int         NVEC  = 6;
  // each entry: {sub-address, data}
  localparam logic [15:0] VEC [NVEC] = '{
    {8'h00, 8'h3C}, {8'hFF, 8'h00}, {8'h80, 8'hFF},
    {8'h7F, 8'hA5}, {8'h01, 8'h5A}, {8'hC3, 8'h96}
  };

  logic          clk;
  logic          rst_n;
  logic          scl_m;
  logic          sda_m;
  logic          sda_line;
  logic          sda_pull;
  logic [AW-1:0] reg_addr;
  logic [7:0]    reg_wdata;
  logic          reg_we;
  logic [7:0]    reg_rdata;

  logic [7:0] bank  [NREG];
  logic [7:0] model [NREG];
  logic [AW-1:0] exp_ptr;
  int checks;
  int errors;
  int we_cnt;
  int edge_viol;
  logic pull_prev;

  assign sda_line  = sda_m & ~sda_pull;
  assign reg_rdata = bank[reg_addr];

  i2c_reg_target #(
    .DEV_ADDR(DEV),
    .AW      (AW)
  ) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_m),
    .sda_i      (sda_line),
    .sda_pull_o (sda_pull),
    .reg_addr_o (reg_addr),
    .reg_wdata_o(reg_wdata),
    .reg_we_o   (reg_we),
    .reg_rdata_i(reg_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (reg_we) begin
      bank[reg_addr] <= reg_wdata;
      we_cnt <= we_cnt + 1;
    end
  end

  // R10: pull must not move while the bus clock is high
  always @(negedge clk) begin
    if (rst_n && (sda_pull !== pull_prev) && scl_m) edge_viol = edge_viol + 1;
    pull_prev = sda_pull;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic ok, input string req, input int act, input int expv);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic do_start;
    sda_m = 1'b1; tick(10);
    scl_m = 1'b1; tick(20);
    sda_m = 1'b0; tick(20);
    scl_m = 1'b0; tick(10);
  endtask

  task automatic do_stop;
    sda_m = 1'b0; tick(10);
    scl_m = 1'b1; tick(20);
    sda_m = 1'b1; tick(20);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(10);
      scl_m = 1'b1; tick(20);
      scl_m = 1'b0; tick(10);
    end
    sda_m = 1'b1; tick(10);
    scl_m = 1'b1; tick(10);
    acked = !sda_line;
    tick(10);
    scl_m = 1'b0; tick(10);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(10);
      scl_m = 1'b1; tick(10);
      b[i] = sda_line;
      tick(10);
      scl_m = 1'b0;
    end
    tick(5);
    sda_m = mack ? 1'b0 : 1'b1; tick(5);
    scl_m = 1'b1; tick(20);
    scl_m = 1'b0; tick(5);
    sda_m = 1'b1; tick(5);
  endtask

  // write transfer: sub-address then n bytes of seed + k*0x13
  task automatic write_seq(input logic [7:0] sub, input int n, input logic [7:0] seed,
                           input string req);
    logic ack;
    logic [7:0] d;
    do_start;
    send_byte({DEV, 1'b0}, ack);
    check(ack, "R3 address ack", ack, 1);
    send_byte(sub, ack);
    check(ack, "R3 sub-address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      d = seed + 8'(k * 8'h13);
      send_byte(d, ack);
      check(ack, req, ack, 1);
      model[8'(sub + k)] = d;
    end
    do_stop;
    exp_ptr = 8'(sub + n);
  endtask

  task automatic read_body(input int n, input string req);
    logic [7:0] d;
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, d);
      check(d == model[exp_ptr], req, d, model[exp_ptr]);
      exp_ptr = exp_ptr + 1'b1;
    end
    do_stop;
    check(sda_pull == 1'b0, "R8 released after NACK", sda_pull, 0);
  endtask

  task automatic read_rand(input logic [7:0] sub, input int n, input string req);
    logic ack;
    do_start;
    send_byte({DEV, 1'b0}, ack);
    send_byte(sub, ack);
    do_start;
    send_byte({DEV, 1'b1}, ack);
    check(ack, "R6 read address ack", ack, 1);
    exp_ptr = sub;
    read_body(n, req);
  endtask

  task automatic read_cur(input int n, input string req);
    logic ack;
    do_start;
    send_byte({DEV, 1'b1}, ack);
    check(ack, "R6 read address ack", ack, 1);
    read_body(n, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors = errors + 1;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic ack;
    int   we_before;
    checks = 0; errors = 0; we_cnt = 0; edge_viol = 0;
    pull_prev = 1'b0;
    scl_m = 1'b1; sda_m = 1'b1; rst_n = 1'b0;
    for (int i = 0; i < NREG; i++) begin
      bank[i]  = 8'(i * 7 + 3);
      model[i] = 8'(i * 7 + 3);
    end
    exp_ptr = '0;
    tick(5);
    rst_n = 1'b1;
    tick(10);

    // reset state
    check(sda_pull == 1'b0, "R2 reset pull", sda_pull, 0);
    check(reg_we == 1'b0, "R4 reset strobe", reg_we, 0);
    check(reg_addr == 8'h00, "R9 reset pointer", reg_addr, 0);

    // table: byte write then random read-back
    for (int v = 0; v < NVEC; v++) begin
      write_seq(VEC[v][15:8], 1, VEC[v][7:0], "R4 byte write ack");
      check(bank[VEC[v][15:8]] == VEC[v][7:0], "R4 bank content",
            bank[VEC[v][15:8]], VEC[v][7:0]);
      read_rand(VEC[v][15:8], 1, "R7 random read");
    end

    // wrong device address is ignored
    we_before = we_cnt;
    do_start;
    send_byte({DEV ^ 7'h01, 1'b0}, ack);
    check(!ack, "R2 foreign address nack", ack, 0);
    send_byte(8'h10, ack);
    check(!ack, "R2 foreign byte nack", ack, 0);
    send_byte(8'hEE, ack);
    do_stop;
    check(we_cnt == we_before, "R2 no write", we_cnt, we_before);

    // multi-byte write across the top
    write_seq(8'hFD, 5, 8'h41, "R5 burst ack");
    for (int k = 0; k < 5; k++) begin
      check(bank[8'(8'hFD + k)] == model[8'(8'hFD + k)], "R5 R9 burst wrap",
            bank[8'(8'hFD + k)], model[8'(8'hFD + k)]);
    end
    read_cur(1, "R6 R9 current read after burst");

    // sequential random read across the top, then pointer persists
    read_rand(8'hFE, 4, "R8 sequential random read");
    read_cur(3, "R8 R9 sequential current read");

    // START inside a data byte aborts it
    we_before = we_cnt;
    do_start;
    send_byte({DEV, 1'b0}, ack);
    send_byte(8'h40, ack);
    for (int i = 0; i < 4; i++) begin
      sda_m = 1'b1; tick(10);
      scl_m = 1'b1; tick(20);
      scl_m = 1'b0; tick(10);
    end
    do_start;
    send_byte({DEV, 1'b1}, ack);
    check(ack, "R1 address after repeated START", ack, 1);
    exp_ptr = 8'h40;
    read_body(1, "R1 aborted byte not written");
    check(we_cnt == we_before, "R1 no write on abort", we_cnt, we_before);

    check(edge_viol == 0, "R10 pull change while clock high", edge_viol, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule